// File: doc/BRIEF.md
# I2C Bus Hang Guard

The block sits next to an I2C protocol engine and watches the two bus lines for the ways a bus can hang. A down-counter measures how long SCL stays low. It reloads from an 8-bit limit on every falling edge of SCL. When the count runs out, the block does one of two things. If the engine is waiting to start a transfer, the block grants forced access with a start pulse. Otherwise it resets the engine and raises a stuck-clock flag, which shows as status code 78h. Each count step is one tick of an internal prescaler, so the limit scales with `PRESC_DIV`.

A second part flags a bus error. This happens when a START or STOP condition appears while the engine reports that an address, data or acknowledge bit is in flight.

A third part frees a bus whose SDA line is held low by another device. On request it toggles SCL up to `MAX_PULSES` times, stopping as soon as SDA reads high at the end of a clock-high phase. It then forms a STOP and a START before handing the bus back. Both lines are open-drain: an `_oe` output high means "pull the line low".

Top module: `bus_guard`

## Requirements
- R1: The time-out counter reloads on every falling edge of SCL. With limit T (nonzero), SCL held low for T*PRESC_DIV+2 cycles after the falling edge trips the watchdog; held for T*PRESC_DIV-1 cycles, it does not. A low stretch broken by any high pulse starts a fresh count.
- R2: A limit of zero disables the watchdog: SCL may stay low for any length of time with no reaction.
- R3: A trip while `start_req` is low gives a one-cycle `engine_rst` pulse and sets `scl_stuck`. While `scl_stuck` is set, `stat_code` reads 8'h78. Once SCL is seen high again, the flag clears and `stat_code` reads 8'hF8.
- R4: A trip while `start_req` is high gives a one-cycle `force_start` pulse instead, with no `engine_rst` pulse and no change to `scl_stuck`.
- R5: A START (SDA falls while SCL is high) or a STOP (SDA rises while SCL is high) seen while `in_frame` is high gives a one-cycle `bus_err` pulse and an `engine_rst` pulse. The same conditions with `in_frame` low have no effect.
- R6: A recovery request drives SCL low and releases it in phases of HALF_CYC cycles each. The clock stops after the first high phase that ends with SDA high, or after MAX_PULSES pulses, whichever comes first.
- R7: After the clock pulses, recovery forms a STOP and then a START. It holds both lines low for one phase, ends with a one-cycle `recov_done` pulse, and drives neither line while not busy.
- R8: While `if_active` is low, SCL falling edges do not load the counter, and the watchdog never trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_active | input | 1 | Interface enabled; gates the watchdog |
| tmo_value | input | 8 | SCL-low limit in prescaler ticks, 0 disables |
| start_req | input | 1 | Engine is waiting to issue a START |
| in_frame | input | 1 | Engine is inside an address, data or acknowledge bit |
| recover_req | input | 1 | Start the SDA-release sequence |
| scl_in | input | 1 | Synchronised SCL line level |
| sda_in | input | 1 | Synchronised SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| scl_stuck | output | 1 | SCL-low time-out flag |
| stat_code | output | 8 | 8'h78 when SCL is stuck, otherwise 8'hF8 |
| engine_rst | output | 1 | One-cycle reset to the protocol engine |
| force_start | output | 1 | One-cycle grant of forced bus access |
| bus_err | output | 1 | One-cycle misplaced START/STOP flag |
| recov_busy | output | 1 | Recovery sequence running |
| recov_done | output | 1 | One-cycle end-of-recovery pulse |

## Verification
The assertions assume that `scl_in` and `sda_in` are already synchronised to `clk` and reflect the wired-AND of the block's own drive with other devices. They also assume that `in_frame` reaches the block as a level from the engine. The bench builds both lines as that wired-AND, from the block's `_oe` outputs and from modelled external pull-downs. It changes every input only on the falling clock edge. It also raises `in_frame` only when no recovery is running.

// File: rtl/bguard_pkg.sv
package bguard_pkg;
  localparam logic [7:0] CODE_SCL_STUCK = 8'h78;
  localparam logic [7:0] CODE_BUS_IDLE  = 8'hF8;

  typedef enum logic [2:0] {
    RC_IDLE, RC_CLK_LO, RC_CLK_HI, RC_STP_LO,
    RC_STP_SU, RC_STP_P, RC_STA, RC_HOLD
  } rec_state_t;

  function automatic logic [7:0] status_of(input logic stuck);
    return stuck ? CODE_SCL_STUCK : CODE_BUS_IDLE;
  endfunction

  function automatic logic last_step(input logic [7:0] cnt);
    return cnt == 8'd1;
  endfunction
endpackage

// File: rtl/bg_scl_watch.sv
module bg_scl_watch #(
  parameter int PRESC_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       if_active,
  input  logic       scl_in,
  input  logic [7:0] tmo_value,
  output logic       expire,
  output logic       scl_fall
);
  import bguard_pkg::*;
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

  logic          scl_q, armed, tick;
  logic [PW-1:0] pre;
  logic [7:0]    cnt;

  assign scl_fall = if_active & scl_q & ~scl_in;
  assign tick     = (pre == PW'(PRESC_DIV - 1));
  assign expire   = armed & if_active & ~scl_in & ~scl_fall & tick & last_step(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      armed <= 1'b0;
      pre   <= '0;
      cnt   <= '0;
    end else begin
      scl_q <= scl_in;
      if (scl_fall) begin
        cnt   <= tmo_value;
        pre   <= '0;
        armed <= (tmo_value != 8'd0);
      end else if (armed) begin
        if (scl_in || !if_active) begin
          armed <= 1'b0;
        end else if (tick) begin
          pre <= '0;
          cnt <= cnt - 8'd1;
          if (last_step(cnt)) armed <= 1'b0;
        end else begin
          pre <= pre + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bg_cond_det.sv
module bg_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  assign start_ev = scl_q & scl_in & sda_q & ~sda_in;
  assign stop_ev  = scl_q & scl_in & ~sda_q & sda_in;
endmodule

// File: rtl/bg_recover.sv
module bg_recover #(
  parameter int HALF_CYC   = 4,
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic sda_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done
);
  import bguard_pkg::*;
  localparam int HW  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int PCW = $clog2(MAX_PULSES + 1);

  rec_state_t     st;
  logic [HW-1:0]  ph;
  logic [PCW-1:0] npulse;
  logic           phase_end;

  assign phase_end = (ph == HW'(HALF_CYC - 1));
  assign busy   = (st != RC_IDLE);
  assign scl_oe = (st == RC_CLK_LO) || (st == RC_STP_LO) || (st == RC_HOLD);
  assign sda_oe = (st == RC_STP_LO) || (st == RC_STP_SU) || (st == RC_STA) || (st == RC_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RC_IDLE;
      ph     <= '0;
      npulse <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == RC_IDLE) begin
        ph     <= '0;
        npulse <= '0;
        if (req) st <= RC_CLK_LO;
      end else if (!phase_end) begin
        ph <= ph + HW'(1);
      end else begin
        ph <= '0;
        unique case (st)
          RC_CLK_LO: st <= RC_CLK_HI;
          RC_CLK_HI: begin
            npulse <= npulse + PCW'(1);
            if (sda_in || npulse == PCW'(MAX_PULSES - 1)) st <= RC_STP_LO;
            else st <= RC_CLK_LO;
          end
          RC_STP_LO: st <= RC_STP_SU;
          RC_STP_SU: st <= RC_STP_P;
          RC_STP_P:  st <= RC_STA;
          RC_STA:    st <= RC_HOLD;
          RC_HOLD: begin
            st   <= RC_IDLE;
            done <= 1'b1;
          end
          default:   st <= RC_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bus_guard.sv
module bus_guard #(
  parameter int PRESC_DIV  = 4,
  parameter int HALF_CYC   = 4,
  parameter int MAX_PULSES = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       if_active,
  input  logic [7:0] tmo_value,
  input  logic       start_req,
  input  logic       in_frame,
  input  logic       recover_req,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       scl_stuck,
  output logic [7:0] stat_code,
  output logic       engine_rst,
  output logic       force_start,
  output logic       bus_err,
  output logic       recov_busy,
  output logic       recov_done
);
  import bguard_pkg::*;

  logic expire, scl_fall, start_ev, stop_ev, berr_now, trip_rst;

  bg_scl_watch #(.PRESC_DIV(PRESC_DIV)) u_watch (
    .clk(clk), .rst_n(rst_n), .if_active(if_active), .scl_in(scl_in),
    .tmo_value(tmo_value), .expire(expire), .scl_fall(scl_fall)
  );

  bg_cond_det u_det (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  bg_recover #(.HALF_CYC(HALF_CYC), .MAX_PULSES(MAX_PULSES)) u_rec (
    .clk(clk), .rst_n(rst_n), .req(recover_req), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(recov_busy), .done(recov_done)
  );

  assign berr_now  = (start_ev | stop_ev) & in_frame & ~recov_busy;
  assign trip_rst  = expire & ~start_req;
  assign stat_code = status_of(scl_stuck);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_stuck   <= 1'b0;
      engine_rst  <= 1'b0;
      force_start <= 1'b0;
      bus_err     <= 1'b0;
    end else begin
      engine_rst  <= trip_rst | berr_now;
      force_start <= expire & start_req;
      bus_err     <= berr_now;
      if (trip_rst)    scl_stuck <= 1'b1;
      else if (scl_in) scl_stuck <= 1'b0;
    end
  end
endmodule

// File: rtl/bg_checker.sv
module bg_checker #(
  parameter int MAX_PULSES = 9
) (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic in_frame,
  input logic scl_stuck,
  input logic engine_rst,
  input logic bus_err,
  input logic force_start,
  input logic scl_oe,
  input logic sda_oe,
  input logic recov_busy,
  input logic recov_done
);
  int unsigned oe_rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_rises <= 0;
    else if (!recov_busy) oe_rises <= 0;
    else if (scl_oe && !$past(scl_oe)) oe_rises <= oe_rises + 1;
  end

  a_r3_stuck_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    scl_stuck |-> !$past(scl_in));
  a_r3_engine_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
    engine_rst |-> ($rose(scl_stuck) || bus_err));
  a_r4_force_not_stuck: assert property (@(posedge clk) disable iff (!rst_n)
    force_start |-> !$rose(scl_stuck));
  a_r5_err_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(in_frame));
  a_r6_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    oe_rises <= MAX_PULSES + 2);
  a_r7_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !recov_busy |-> (!scl_oe && !sda_oe));
  a_r7_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    recov_done |-> (!recov_busy && $past(recov_busy)));
endmodule

bind bus_guard bg_checker #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .in_frame(in_frame),
  .scl_stuck(scl_stuck), .engine_rst(engine_rst), .bus_err(bus_err),
  .force_start(force_start), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .recov_busy(recov_busy), .recov_done(recov_done)
);

// File: tb/tb_bus_guard.sv
module tb_bus_guard;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_active = 1'b1, start_req = 1'b0, in_frame = 1'b0, recover_req = 1'b0;
  logic [7:0] tmo_value = 8'd0;
  logic ext_scl_low = 1'b0, tb_sda_low = 1'b0, dev_sda_low = 1'b0;
  logic scl_oe, sda_oe, scl_stuck, engine_rst, force_start, bus_err, recov_busy, recov_done;
  logic [7:0] stat_code;
  logic scl_bus, sda_bus;

  assign scl_bus = ~scl_oe & ~ext_scl_low;
  assign sda_bus = ~sda_oe & ~tb_sda_low & ~dev_sda_low;

  bus_guard dut (
    .clk(clk), .rst_n(rst_n), .if_active(if_active), .tmo_value(tmo_value),
    .start_req(start_req), .in_frame(in_frame), .recover_req(recover_req),
    .scl_in(scl_bus), .sda_in(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .scl_stuck(scl_stuck), .stat_code(stat_code), .engine_rst(engine_rst),
    .force_start(force_start), .bus_err(bus_err), .recov_busy(recov_busy),
    .recov_done(recov_done)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  int n_rst = 0, n_force = 0, n_err = 0, n_done = 0, n_oe_rise = 0, n_scl_rise = 0;
  int stop_at = 0, start_at = 0, rel_after = 0;
  logic p_scl = 1'b1, p_sda = 1'b1, p_oe = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (engine_rst)  n_rst++;
    if (force_start) n_force++;
    if (bus_err)     n_err++;
    if (recov_done)  n_done++;
    if (scl_oe && !p_oe) n_oe_rise++;
    if (scl_bus && !p_scl) begin
      n_scl_rise++;
      if (n_scl_rise >= rel_after) dev_sda_low = 1'b0;
    end
    if (p_scl && scl_bus && !p_sda && sda_bus) stop_at = cyc;
    if (p_scl && scl_bus && p_sda && !sda_bus && recov_busy) start_at = cyc;
    p_scl = scl_bus; p_sda = sda_bus; p_oe = scl_oe;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung, actual cyc=%0d expected <150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input logic ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int trip_len(input int t);
    return t * DIV;
  endfunction

  // {limit, expect trip}
  localparam logic [8:0] VECS [0:5] = '{
    {8'd3, 1'b1}, {8'd3, 1'b0}, {8'd1, 1'b1},
    {8'd0, 1'b0}, {8'd20, 1'b1}, {8'd7, 1'b0}
  };

  task automatic run_recovery(input int k, input int exp_rises, input logic chk_order);
    int t0;
    n_oe_rise = 0; n_scl_rise = 0; rel_after = k; dev_sda_low = 1'b1;
    stop_at = 0; start_at = 0; t0 = cyc;
    recover_req = 1'b1; wait_n(1); recover_req = 1'b0;
    for (int i = 0; i < 600 && n_done == 0; i++) wait_n(1);
    check(n_done == 1, "R7 done pulse", n_done, 1);
    check(n_oe_rise == exp_rises, "R6 scl pulse count", n_oe_rise, exp_rises);
    if (chk_order)
      check(stop_at > t0 && start_at > stop_at, "R7 STOP then START", start_at, stop_at);
    wait_n(2);
    check(!scl_oe && !sda_oe && !recov_busy, "R7 lines released", {scl_oe, sda_oe}, 0);
    dev_sda_low = 1'b0; n_done = 0;
    wait_n(4);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    check(stat_code == 8'hF8 && !scl_oe && !sda_oe && !recov_busy, "R3 reset state", stat_code, 8'hF8);

    // R1 R2 R3: vector table
    for (int v = 0; v < 6; v++) begin
      int t, hold, r0;
      logic trip;
      t = int'(VECS[v][8:1]);
      trip = VECS[v][0];
      hold = trip ? trip_len(t) + 2 : (t == 0 ? 80 : trip_len(t) - 1);
      tmo_value = VECS[v][8:1];
      r0 = n_rst;
      ext_scl_low = 1'b1;
      wait_n(hold);
      check(stat_code == (trip ? 8'h78 : 8'hF8), "R1/R2 trip status", stat_code, trip ? 8'h78 : 8'hF8);
      check(scl_stuck == trip, "R3 stuck flag", scl_stuck, trip);
      ext_scl_low = 1'b0;
      wait_n(3);
      check(n_rst - r0 == int'(trip), "R3 engine reset pulses", n_rst - r0, trip);
      check(stat_code == 8'hF8, "R3 clear on SCL high", stat_code, 8'hF8);
    end

    // R1 reload: two low stretches split by a one-cycle high pulse
    tmo_value = 8'd3;
    ext_scl_low = 1'b1; wait_n(10);
    ext_scl_low = 1'b0; wait_n(1);
    ext_scl_low = 1'b1; wait_n(10);
    check(!scl_stuck, "R1 reload on falling edge", scl_stuck, 0);
    wait_n(4);
    check(scl_stuck, "R1 trip after reload", scl_stuck, 1);
    ext_scl_low = 1'b0; wait_n(3);

    // R8 inactive interface
    if_active = 1'b0; tmo_value = 8'd2;
    ext_scl_low = 1'b1; wait_n(30);
    check(!scl_stuck && stat_code == 8'hF8, "R8 inactive no trip", stat_code, 8'hF8);
    ext_scl_low = 1'b0; wait_n(2); if_active = 1'b1; wait_n(2);

    // R4 forced access
    begin
      int f0, r0;
      f0 = n_force; r0 = n_rst;
      start_req = 1'b1; tmo_value = 8'd2;
      ext_scl_low = 1'b1; wait_n(trip_len(2) + 3);
      check(n_force - f0 == 1, "R4 force pulse", n_force - f0, 1);
      check(n_rst == r0 && !scl_stuck, "R4 no reset or stuck", n_rst - r0, 0);
      ext_scl_low = 1'b0; start_req = 1'b0; wait_n(3);
    end

    // R5 misplaced START/STOP
    begin
      int e0, r0;
      tmo_value = 8'd0;
      e0 = n_err; r0 = n_rst;
      in_frame = 1'b1;
      tb_sda_low = 1'b1; wait_n(3);
      check(n_err - e0 == 1 && n_rst - r0 == 1, "R5 START in frame", n_err - e0, 1);
      tb_sda_low = 1'b0; wait_n(3);
      check(n_err - e0 == 2 && n_rst - r0 == 2, "R5 STOP in frame", n_err - e0, 2);
      in_frame = 1'b0;
      tb_sda_low = 1'b1; wait_n(3);
      tb_sda_low = 1'b0; wait_n(3);
      check(n_err - e0 == 2 && n_rst - r0 == 2, "R5 outside frame ignored", n_err - e0, 2);
    end

    // R6 R7 recovery
    run_recovery(3, 5, 1'b1);
    run_recovery(1, 3, 1'b1);
    run_recovery(50, 11, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule